// File: doc/BRIEF.md
# Processor Status Register Unit

This block holds a 16-bit processor status word. The low byte carries the condition codes: carry, overflow, zero, negative and an extend flag. The high byte carries a 3-bit interrupt priority mask, a supervisor bit and a trace bit. Other bits do not exist and always read zero.

The ALU sends flag updates with a per-flag write mask, its result, the operand size and the carry and overflow outputs. The unit works out the zero and negative flags itself, at the size of the operation. Instruction execution can write the whole word or only the condition codes. The high byte can be written only while the supervisor bit is set. A whole-word write in user mode changes only the low byte and raises a one-cycle privilege-violation pulse. The mask, supervisor and trace fields are brought out to control logic.

A small trace state machine watches instruction completions. It has three states. TRC_OFF means the trace bit is clear. TRC_WATCH means tracing is on and the machine is waiting for an instruction to complete. TRC_FIRE means a trace request is active. It takes the same transitions from every state:
- trace bit set and instruction done goes to TRC_FIRE;
- trace bit set without instruction done goes to TRC_WATCH;
- trace bit clear goes to TRC_OFF.

The trace request output is high only in TRC_FIRE.

Top module: `psr_unit`

## Requirements
- R1: After reset the status word reads 0x2700: supervisor bit set, interrupt mask 111, trace and all condition codes clear. The trace-request and privilege-violation outputs are low.
- R2: When alu_valid is high, each flag whose alu_mask bit is set is loaded on the next clock edge. The mask bits select flags by bit position: bit 0 carry, bit 1 overflow, bit 2 zero, bit 3 negative, bit 4 extend. Carry is loaded from alu_carry and overflow from alu_ovf. Flags whose mask bit is clear keep their value.
- R3: The extend flag (status bit 4) takes alu_carry only when alu_mask bit 4 is set. An update that sets only the carry mask bit leaves extend unchanged.
- R4: Zero and negative follow the operation size. alu_size 00 selects byte (result bits 7:0, sign bit 7). 01 selects word (bits 15:0, sign bit 15). 10 or 11 selects long (the full result, sign bit DW-1).
- R5: A write with wr_ccr_only=1 loads status bits 4:0 from wr_data[4:0] in either mode and leaves bits 15:8 unchanged.
- R6: A whole-word write (wr_ccr_only=0) while supervisor is set loads the implemented bits from wr_data. These are bit 15 trace, bit 13 supervisor, bits 10:8 mask and bits 4:0.
- R7: A whole-word write while supervisor is clear changes only bits 4:0. In the following cycle it pulses priv_viol high for exactly one cycle. In user mode, bits 15:8 never change.
- R8: Bits 5, 6, 7, 11, 12 and 14 always read zero, whatever is written.
- R9: When an explicit write and an ALU update arrive in the same cycle, the explicit write sets the condition codes and the ALU update is dropped.
- R10: In the cycle after insn_done is high with the trace bit set, trace_req is high. trace_req is low when the trace bit was clear.
- R11: int_mask, supv and trace_en equal status bits 10:8, 13 and 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_valid | input | 1 | ALU flag update request |
| alu_mask | input | 5 | Per-flag write mask (bit 0 C, 1 V, 2 Z, 3 N, 4 X) |
| alu_size | input | 2 | Operation size: 00 byte, 01 word, 1x long |
| alu_result | input | DW | ALU result used for zero and negative |
| alu_carry | input | 1 | ALU carry out |
| alu_ovf | input | 1 | ALU overflow |
| wr_en | input | 1 | Explicit write request |
| wr_ccr_only | input | 1 | 1: condition codes only, 0: whole word |
| wr_data | input | 16 | Write data |
| insn_done | input | 1 | An instruction completed this cycle |
| sr_q | output | 16 | Status word |
| int_mask | output | 3 | Interrupt priority mask |
| supv | output | 1 | Supervisor bit |
| trace_en | output | 1 | Trace bit |
| trace_req | output | 1 | Trace exception request |
| priv_viol | output | 1 | One-cycle privilege-violation pulse |

## Verification
The case hardest to reach from the ports is user mode. Supervisor can only be cleared by a privileged whole-word write, and the unit cannot set it again without a reset. The stimulus drops supervisor with such a write partway through the vector table. The rest of the table then runs in user mode, where it attempts a rejected system-byte write and checks that priv_viol lasts exactly one cycle. A directed test resets the unit, sets trace while clearing supervisor in a single write, checks the request that follows an instruction completion, and then shows that a user write cannot turn trace off.

// File: rtl/psr_pkg.sv
package psr_pkg;

    localparam int SR_W     = 16;
    localparam int NFLAG    = 5;
    localparam int IPM_W    = 3;

    localparam int BIT_C    = 0;
    localparam int BIT_V    = 1;
    localparam int BIT_Z    = 2;
    localparam int BIT_N    = 3;
    localparam int BIT_X    = 4;
    localparam int IPM_LO   = 8;
    localparam int BIT_S    = 13;
    localparam int BIT_T    = 15;

    localparam logic [SR_W-1:0]  IMPL_MASK = 16'hA71F;
    localparam logic [IPM_W-1:0] IPM_RESET = '1;
    localparam logic             S_RESET   = 1'b1;
    localparam logic             T_RESET   = 1'b0;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_WORD  = 2'b01,
        SZ_LONG  = 2'b10,
        SZ_LONG2 = 2'b11
    } op_size_e;

    typedef enum logic [1:0] {
        TRC_OFF   = 2'b00,
        TRC_WATCH = 2'b01,
        TRC_FIRE  = 2'b10
    } trace_state_e;

endpackage

// File: rtl/psr_flag_eval.sv
module psr_flag_eval
    import psr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] result,
    input  logic [1:0]    size,
    input  logic          carry,
    input  logic          ovf,
    output logic [NFLAG-1:0] flags
);
    localparam int BYTE_MSB = 7;
    localparam int WORD_MSB = 15;
    localparam int LONG_MSB = DW - 1;

    logic z_bit;
    logic n_bit;

    always_comb begin
        unique case (op_size_e'(size))
            SZ_BYTE: begin
                n_bit = result[BYTE_MSB];
                z_bit = (result[BYTE_MSB:0] == '0);
            end
            SZ_WORD: begin
                n_bit = result[WORD_MSB];
                z_bit = (result[WORD_MSB:0] == '0);
            end
            default: begin
                n_bit = result[LONG_MSB];
                z_bit = (result == '0);
            end
        endcase
    end

    always_comb begin
        flags        = '0;
        flags[BIT_C] = carry;
        flags[BIT_V] = ovf;
        flags[BIT_Z] = z_bit;
        flags[BIT_N] = n_bit;
        flags[BIT_X] = carry;
    end
endmodule

// File: rtl/psr_ccr.sv
module psr_ccr
    import psr_pkg::*;
#(
    parameter int NF = NFLAG
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_set,
    input  logic [NF-1:0] wr_flags,
    input  logic          alu_set,
    input  logic [NF-1:0] alu_mask,
    input  logic [NF-1:0] alu_flags,
    output logic [NF-1:0] flags_q
);
    for (genvar i = 0; i < NF; i++) begin : g_flag
        logic flag_r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_r <= 1'b0;
            end else if (wr_set) begin
                flag_r <= wr_flags[i];
            end else if (alu_set && alu_mask[i]) begin
                flag_r <= alu_flags[i];
            end
        end
        assign flags_q[i] = flag_r;
    end
endmodule

// File: rtl/psr_sys.sv
module psr_sys
    import psr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_full,
    input  logic [IPM_W-1:0] wr_ipm,
    input  logic             wr_s,
    input  logic             wr_t,
    output logic [IPM_W-1:0] ipm_q,
    output logic             s_q,
    output logic             t_q,
    output logic             viol_q
);
    logic grant;
    logic deny;

    assign grant = wr_full &&  s_q;
    assign deny  = wr_full && !s_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ipm_q <= IPM_RESET;
            s_q   <= S_RESET;
            t_q   <= T_RESET;
        end else if (grant) begin
            ipm_q <= wr_ipm;
            s_q   <= wr_s;
            t_q   <= wr_t;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            viol_q <= 1'b0;
        end else begin
            viol_q <= deny;
        end
    end
endmodule

// File: rtl/psr_trace_fsm.sv
module psr_trace_fsm
    import psr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trace_on,
    input  logic insn_done,
    output logic trace_req
);
    trace_state_e state_q;
    trace_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TRC_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRC_OFF: begin
                if (trace_on) begin
                    state_d = insn_done ? TRC_FIRE : TRC_WATCH;
                end
            end
            TRC_WATCH: begin
                if (!trace_on) begin
                    state_d = TRC_OFF;
                end else if (insn_done) begin
                    state_d = TRC_FIRE;
                end
            end
            TRC_FIRE: begin
                if (!trace_on) begin
                    state_d = TRC_OFF;
                end else begin
                    state_d = insn_done ? TRC_FIRE : TRC_WATCH;
                end
            end
            default: state_d = TRC_OFF;
        endcase
    end

    always_comb begin
        trace_req = (state_q == TRC_FIRE);
    end
endmodule

// File: rtl/psr_unit.sv
module psr_unit
    import psr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alu_valid,
    input  logic [4:0]    alu_mask,
    input  logic [1:0]    alu_size,
    input  logic [DW-1:0] alu_result,
    input  logic          alu_carry,
    input  logic          alu_ovf,
    input  logic          wr_en,
    input  logic          wr_ccr_only,
    input  logic [15:0]   wr_data,
    input  logic          insn_done,
    output logic [15:0]   sr_q,
    output logic [2:0]    int_mask,
    output logic          supv,
    output logic          trace_en,
    output logic          trace_req,
    output logic          priv_viol
);
    logic [NFLAG-1:0] alu_flags;
    logic [NFLAG-1:0] ccr_q;
    logic [IPM_W-1:0] ipm_q;
    logic             s_q;
    logic             t_q;
    logic             unused_wr_bits;

    assign unused_wr_bits = ^{wr_data[7:5], wr_data[12:11], wr_data[14]};

    psr_flag_eval #(.DW(DW)) u_eval (
        .result (alu_result),
        .size   (alu_size),
        .carry  (alu_carry),
        .ovf    (alu_ovf),
        .flags  (alu_flags)
    );

    psr_ccr #(.NF(NFLAG)) u_ccr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_set    (wr_en),
        .wr_flags  (wr_data[NFLAG-1:0]),
        .alu_set   (alu_valid),
        .alu_mask  (alu_mask),
        .alu_flags (alu_flags),
        .flags_q   (ccr_q)
    );

    psr_sys u_sys (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_full (wr_en && !wr_ccr_only),
        .wr_ipm  (wr_data[IPM_LO +: IPM_W]),
        .wr_s    (wr_data[BIT_S]),
        .wr_t    (wr_data[BIT_T]),
        .ipm_q   (ipm_q),
        .s_q     (s_q),
        .t_q     (t_q),
        .viol_q  (priv_viol)
    );

    psr_trace_fsm u_trace (
        .clk       (clk),
        .rst_n     (rst_n),
        .trace_on  (t_q),
        .insn_done (insn_done),
        .trace_req (trace_req)
    );

    always_comb begin
        sr_q                     = '0;
        sr_q[NFLAG-1:0]          = ccr_q;
        sr_q[IPM_LO +: IPM_W]    = ipm_q;
        sr_q[BIT_S]              = s_q;
        sr_q[BIT_T]              = t_q;
    end

    assign int_mask = ipm_q;
    assign supv     = s_q;
    assign trace_en = t_q;
endmodule

// File: rtl/psr_unit_chk.sv
module psr_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        alu_valid,
    input logic [4:0]  alu_mask,
    input logic        wr_en,
    input logic        wr_ccr_only,
    input logic        insn_done,
    input logic [15:0] sr_q,
    input logic        supv,
    input logic        trace_en,
    input logic        trace_req,
    input logic        priv_viol
);
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_q & 16'h58E0) == 16'h0000); // R8

    AST_VIOL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        priv_viol |-> $past(wr_en && !wr_ccr_only && !supv)); // R7

    AST_USER_SYS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !supv |=> $stable(sr_q[15:8])); // R7

    AST_CCR_WRITE_SYS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ccr_only) |=> $stable(sr_q[15:8])); // R5

    AST_EXTEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !(alu_valid && alu_mask[4])) |=> $stable(sr_q[4])); // R3

    AST_TRACE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        trace_req |-> $past(trace_en && insn_done)); // R10
endmodule

bind psr_unit psr_unit_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .alu_valid   (alu_valid),
    .alu_mask    (alu_mask),
    .wr_en       (wr_en),
    .wr_ccr_only (wr_ccr_only),
    .insn_done   (insn_done),
    .sr_q        (sr_q),
    .supv        (supv),
    .trace_en    (trace_en),
    .trace_req   (trace_req),
    .priv_viol   (priv_viol)
);

// File: tb/psr_unit_tb_top.sv
module psr_unit_tb_top;
    localparam int DW = 32;
    localparam int NV = 14;

    typedef struct packed {
        logic          alu_v;
        logic [4:0]    mask;
        logic [1:0]    size;
        logic          carry;
        logic          ovf;
        logic [31:0]   result;
        logic          wr_en;
        logic          ccr_only;
        logic [15:0]   wdata;
        logic [15:0]   exp_sr;
        logic          exp_pv;
        logic [7:0]    req;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b1, 5'h1F, 2'd2, 1'b1, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 16'h0000, 16'h2715, 1'b0, 8'd2},  // R2 all flags
        '{1'b1, 5'h01, 2'd2, 1'b0, 1'b0, 32'h0000_0005, 1'b0, 1'b0, 16'h0000, 16'h2714, 1'b0, 8'd3},  // R3 carry only, X held
        '{1'b1, 5'h0E, 2'd0, 1'b0, 1'b1, 32'h0000_0180, 1'b0, 1'b0, 16'h0000, 16'h271A, 1'b0, 8'd4},  // R4 byte negative
        '{1'b1, 5'h0C, 2'd1, 1'b0, 1'b0, 32'h0001_0000, 1'b0, 1'b0, 16'h0000, 16'h2716, 1'b0, 8'd4},  // R4 word zero
        '{1'b1, 5'h0C, 2'd2, 1'b0, 1'b0, 32'h8000_0000, 1'b0, 1'b0, 16'h0000, 16'h271A, 1'b0, 8'd4},  // R4 long negative
        '{1'b0, 5'h00, 2'd0, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 1'b1, 16'hFFE5, 16'h2705, 1'b0, 8'd5},  // R5 ccr write, R8
        '{1'b0, 5'h00, 2'd0, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 1'b0, 16'hFFFF, 16'hA71F, 1'b0, 8'd6},  // R6 full write, R8
        '{1'b1, 5'h1F, 2'd2, 1'b1, 1'b0, 32'h0000_0000, 1'b1, 1'b0, 16'h2300, 16'h2300, 1'b0, 8'd9},  // R9 full beats ALU
        '{1'b1, 5'h1F, 2'd2, 1'b0, 1'b0, 32'h0000_0001, 1'b1, 1'b1, 16'h0003, 16'h2303, 1'b0, 8'd9},  // R9 ccr beats ALU
        '{1'b0, 5'h00, 2'd0, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 1'b0, 16'h0012, 16'h0012, 1'b0, 8'd6},  // R6 drop supervisor
        '{1'b0, 5'h00, 2'd0, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 1'b0, 16'hA70F, 16'h000F, 1'b1, 8'd7},  // R7 user full write
        '{1'b1, 5'h10, 2'd2, 1'b1, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 16'h0000, 16'h001F, 1'b0, 8'd7},  // R7 pulse ends, R3 X set
        '{1'b1, 5'h10, 2'd2, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 16'h0000, 16'h000F, 1'b0, 8'd3},  // R3 X cleared
        '{1'b1, 5'h00, 2'd2, 1'b1, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 16'h0000, 16'h000F, 1'b0, 8'd2}   // R2 empty mask
    };

    logic          clk;
    logic          rst_n;
    logic          alu_valid;
    logic [4:0]    alu_mask;
    logic [1:0]    alu_size;
    logic [DW-1:0] alu_result;
    logic          alu_carry;
    logic          alu_ovf;
    logic          wr_en;
    logic          wr_ccr_only;
    logic [15:0]   wr_data;
    logic          insn_done;
    logic [15:0]   sr_q;
    logic [2:0]    int_mask;
    logic          supv;
    logic          trace_en;
    logic          trace_req;
    logic          priv_viol;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    psr_unit #(.DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .alu_valid(alu_valid), .alu_mask(alu_mask),
        .alu_size(alu_size), .alu_result(alu_result), .alu_carry(alu_carry),
        .alu_ovf(alu_ovf), .wr_en(wr_en), .wr_ccr_only(wr_ccr_only),
        .wr_data(wr_data), .insn_done(insn_done), .sr_q(sr_q),
        .int_mask(int_mask), .supv(supv), .trace_en(trace_en),
        .trace_req(trace_req), .priv_viol(priv_viol)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%04h expected 0x%04h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        alu_valid   = 1'b0;
        alu_mask    = '0;
        alu_size    = '0;
        alu_result  = '0;
        alu_carry   = 1'b0;
        alu_ovf     = 1'b0;
        wr_en       = 1'b0;
        wr_ccr_only = 1'b0;
        wr_data     = '0;
        insn_done   = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic check_reset_state();
        check("R1", "status word", sr_q, 16'h2700);
        check("R1", "trace_req", {15'd0, trace_req}, 16'h0000);
        check("R1", "priv_viol", {15'd0, priv_viol}, 16'h0000);
        check("R11", "int_mask", {13'd0, int_mask}, 16'h0007);
        check("R11", "supv", {15'd0, supv}, 16'h0001);
        check("R11", "trace_en", {15'd0, trace_en}, 16'h0000);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        do_reset();
        check_reset_state();  // R1, R11

        // vector table: drive on a falling edge, check one cycle later
        for (int i = 0; i < NV; i++) begin
            alu_valid   = VECS[i].alu_v;
            alu_mask    = VECS[i].mask;
            alu_size    = VECS[i].size;
            alu_carry   = VECS[i].carry;
            alu_ovf     = VECS[i].ovf;
            alu_result  = VECS[i].result;
            wr_en       = VECS[i].wr_en;
            wr_ccr_only = VECS[i].ccr_only;
            wr_data     = VECS[i].wdata;
            @(negedge clk);
            check($sformatf("R%0d", VECS[i].req), $sformatf("vector %0d status", i),
                  sr_q, VECS[i].exp_sr);
            check($sformatf("R%0d", VECS[i].req), $sformatf("vector %0d priv_viol", i),
                  {15'd0, priv_viol}, {15'd0, VECS[i].exp_pv});
        end
        idle_inputs();

        // R11: user-mode fields after the table
        check("R11", "supv user", {15'd0, supv}, 16'h0000);
        check("R11", "int_mask user", {13'd0, int_mask}, 16'h0000);

        // R10: trace set without supervisor, then instruction completions
        do_reset();
        check_reset_state();
        wr_en = 1'b1; wr_ccr_only = 1'b0; wr_data = 16'h8700;
        @(negedge clk);
        idle_inputs();
        check("R6", "trace word", sr_q, 16'h8700);
        check("R11", "trace_en", {15'd0, trace_en}, 16'h0001);
        check("R10", "no request without completion", {15'd0, trace_req}, 16'h0000);
        insn_done = 1'b1;
        @(negedge clk);
        insn_done = 1'b0;
        check("R10", "request after completion", {15'd0, trace_req}, 16'h0001);
        @(negedge clk);
        check("R10", "request drops", {15'd0, trace_req}, 16'h0000);

        // R7: user write cannot clear trace
        wr_en = 1'b1; wr_ccr_only = 1'b0; wr_data = 16'h0000;
        @(negedge clk);
        idle_inputs();
        check("R7", "trace kept", sr_q, 16'h8700);
        check("R7", "viol pulse", {15'd0, priv_viol}, 16'h0001);
        @(negedge clk);
        check("R7", "viol one cycle", {15'd0, priv_viol}, 16'h0000);

        // R10: no request while trace is clear
        do_reset();
        insn_done = 1'b1;
        @(negedge clk);
        insn_done = 1'b0;
        check("R10", "no request trace clear", {15'd0, trace_req}, 16'h0000);

        // R5: ccr-only write in user mode is allowed and raises no violation
        wr_en = 1'b1; wr_data = 16'h0000;
        @(negedge clk);
        idle_inputs();
        wr_en = 1'b1; wr_ccr_only = 1'b1; wr_data = 16'hFF1B;
        @(negedge clk);
        idle_inputs();
        check("R5", "user ccr write", sr_q, 16'h001B);
        check("R5", "no violation", {15'd0, priv_viol}, 16'h0000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule